// File: doc/BRIEF.md
# Five-hot to index list encoder

The encoder accepts a 16-bit vector in which five bits are expected to be set. It returns the binary positions of those five bits, four bits each, packed into one 20-bit word. The word is meant to be written into a 20-bit wide queue so that a consumer can pull it out later and work on all five positions at once.

The vector is cut into a low byte and a high byte. Each byte addresses its own 256-entry table, and both tables are built at elaboration time.

- The low table lists the set positions from the bottom nibble upward and also returns the number of set bits in the low byte.
- The high table lists its positions (8 to 15) from the top nibble downward.

Because the two lists grow from opposite ends, each output nibble comes from one of two sources. A 2:1 choice driven by the low-byte count selects it. A two-register pipeline keeps each stage to a table lookup or a mux. Vectors whose set-bit count is not five are reported on an error flag, with an all-zero word.

Top module: `fivehot_index_enc`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` and `out_err` are low.
- R2: `out_valid` equals the value `in_valid` had exactly two clock edges earlier.
- R3: For an input with exactly five set bits, `out_idx` holds their positions as 4-bit binary values. Bits 19:16 hold the highest position, and each lower nibble holds the next lower position down to bits 3:0, which holds the lowest.
- R4: Input 16'hC007 produces 20'hFE210 with `out_err` low.
- R5: The result is correct for every split of the five set bits between the low byte (bits 7:0) and the high byte (bits 15:8). This includes all five in the low byte (16'h001F gives 20'h43210) and all five in the high byte (16'hF800 gives 20'hFEDCB).
- R6: An accepted input whose set-bit count is not five produces `out_err` high together with `out_valid`, and `out_idx` equal to zero.
- R7: An input whose low byte alone has more than five set bits is flagged as an error as in R6.
- R8: A new input may be accepted on every clock. Back-to-back inputs each produce their own result, in order.
- R9: While `out_valid` is low, `out_idx` keeps the value of the last result.
- R10: `out_err` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input vector is present this cycle |
| in_vec | input | 16 | Vector expected to carry five set bits |
| out_valid | output | 1 | Result is present this cycle |
| out_idx | output | 20 | Five 4-bit positions, highest in bits 19:16 |
| out_err | output | 1 | Accepted vector did not have exactly five set bits |

## Verification
Every one of the 4368 five-hot vectors is applied back to back and compared with a scan-based model. This covers each possible split of set bits between the two bytes, so it separates a wrong mux boundary from a wrong table entry. The boundary cases isolate single-table paths: all five bits in the low byte, all five in the high byte, and the worked example. Error vectors include zero, all ones, four-hot, six-hot and random counts. Low bytes with six to eight set bits test the case where the low table's list overflows. Idle gaps between results show that the word is held and that the error flag stays low.

// File: rtl/fhe_pkg.sv
package fhe_pkg;

  localparam int unsigned DEF_IN_W = 16;
  localparam int unsigned DEF_HOT  = 5;

  // Width needed to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/fhe_half_lut.sv
// Lookup for one half of the input vector. The table is built at elaboration.
// FROM_TOP = 0: positions packed from slot 0 upward, lowest first.
// FROM_TOP = 1: positions packed from slot HOT-1 downward, highest first.
module fhe_half_lut #(
  parameter int unsigned HALF_W   = 8,
  parameter int unsigned HOT      = 5,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned BASE     = 0,
  parameter bit          FROM_TOP = 1'b0
) (
  input  logic [HALF_W-1:0]    addr,
  output logic [HOT*IDX_W-1:0] slots,
  output logic [CNT_W-1:0]     count
);

  localparam int unsigned DEPTH = 1 << HALF_W;
  localparam int unsigned SW    = HOT * IDX_W;
  localparam int unsigned EW    = SW + CNT_W;

  function automatic logic [EW-1:0] build_entry(input logic [31:0] a);
    logic [EW-1:0] e;
    int            slot;
    int unsigned   n;
    e = '0;
    n = 0;
    if (!FROM_TOP) begin
      slot = 0;
      for (int b = 0; b < int'(HALF_W); b++) begin
        if (a[b]) begin
          if (slot < int'(HOT)) e[slot*IDX_W +: IDX_W] = IDX_W'(BASE + b);
          slot++;
          n++;
        end
      end
    end else begin
      slot = int'(HOT) - 1;
      for (int b = int'(HALF_W) - 1; b >= 0; b--) begin
        if (a[b]) begin
          if (slot >= 0) e[slot*IDX_W +: IDX_W] = IDX_W'(BASE + b);
          slot--;
          n++;
        end
      end
    end
    e[EW-1 -: CNT_W] = CNT_W'(n);
    return e;
  endfunction

  logic [EW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    localparam logic [EW-1:0] ENT = build_entry(32'(a));
    assign rom[a] = ENT;
  end

  logic [EW-1:0] entry;
  always_comb begin
    entry = rom[addr];
    slots = entry[SW-1:0];
    count = entry[EW-1 -: CNT_W];
  end

endmodule

// File: rtl/fhe_merge.sv
// Per-slot 2:1 choice between the two half lists, with zero forcing on error.
module fhe_merge #(
  parameter int unsigned HOT   = 5,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic [HOT*IDX_W-1:0] lo_slots,
  input  logic [HOT*IDX_W-1:0] hi_slots,
  input  logic [CNT_W-1:0]     lo_count,
  input  logic                 bad,
  output logic [HOT*IDX_W-1:0] word
);

  for (genvar k = 0; k < HOT; k++) begin : g_slot
    localparam logic [CNT_W-1:0] KV = CNT_W'(k);
    logic take_lo;
    assign take_lo = (KV < lo_count);
    assign word[k*IDX_W +: IDX_W] = bad     ? '0 :
                                    take_lo ? lo_slots[k*IDX_W +: IDX_W]
                                            : hi_slots[k*IDX_W +: IDX_W];
  end

endmodule

// File: rtl/fivehot_index_enc.sv
module fivehot_index_enc #(
  parameter int unsigned IN_W = fhe_pkg::DEF_IN_W,
  parameter int unsigned HOT  = fhe_pkg::DEF_HOT
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [IN_W-1:0]               in_vec,
  output logic                          out_valid,
  output logic [HOT*$clog2(IN_W)-1:0]   out_idx,
  output logic                          out_err
);

  localparam int unsigned HALF_W = IN_W / 2;
  localparam int unsigned IDX_W  = $clog2(IN_W);
  localparam int unsigned OW     = HOT * IDX_W;
  localparam int unsigned CNT_W  = fhe_pkg::cnt_width(HALF_W);
  localparam int unsigned SUM_W  = CNT_W + 1;

  // Lookups
  logic [OW-1:0]    lo_slots, hi_slots;
  logic [CNT_W-1:0] lo_count, hi_count;

  fhe_half_lut #(
    .HALF_W(HALF_W), .HOT(HOT), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .BASE(0), .FROM_TOP(1'b0)
  ) u_lo_lut (
    .addr (in_vec[HALF_W-1:0]),
    .slots(lo_slots),
    .count(lo_count)
  );

  fhe_half_lut #(
    .HALF_W(HALF_W), .HOT(HOT), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .BASE(HALF_W), .FROM_TOP(1'b1)
  ) u_hi_lut (
    .addr (in_vec[IN_W-1:HALF_W]),
    .slots(hi_slots),
    .count(hi_count)
  );

  // Stage 1 next state
  logic             s1_valid_d, s1_bad_d;
  logic [SUM_W-1:0] pop_sum;

  always_comb begin
    pop_sum    = SUM_W'(lo_count) + SUM_W'(hi_count);
    s1_valid_d = in_valid;
    s1_bad_d   = in_valid && (pop_sum != SUM_W'(HOT));
  end

  // Stage 1 registers
  logic             s1_valid, s1_bad;
  logic [OW-1:0]    s1_lo, s1_hi;
  logic [CNT_W-1:0] s1_lo_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_bad   <= 1'b0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_bad   <= s1_bad_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_lo       <= lo_slots;
      s1_hi       <= hi_slots;
      s1_lo_count <= lo_count;
    end
  end

  // Merge
  logic [OW-1:0] merged;

  fhe_merge #(.HOT(HOT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_merge (
    .lo_slots(s1_lo),
    .hi_slots(s1_hi),
    .lo_count(s1_lo_count),
    .bad     (s1_bad),
    .word    (merged)
  );

  // Stage 2 next state
  logic s2_valid_d, s2_err_d;
  always_comb begin
    s2_valid_d = s1_valid;
    s2_err_d   = s1_valid && s1_bad;
  end

  // Stage 2 registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s2_valid_d;
      out_err   <= s2_err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) out_idx <= merged;
  end

endmodule

// File: rtl/fhe_checker.sv
module fhe_checker #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned HOT  = 5,
  parameter int unsigned OW   = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [IN_W-1:0] in_vec,
  input logic            out_valid,
  input logic [OW-1:0]   out_idx,
  input logic            out_err
);

  localparam int unsigned IDX_W = OW / HOT;

  // Edges seen since reset release, saturating at 2
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_err_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid) |-> (out_err == ($countones($past(in_vec, 2)) != HOT)));

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_idx == '0));

  p_err_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_idx));

  for (genvar k = 1; k < HOT; k++) begin : g_order
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err) |->
        (out_idx[k*IDX_W +: IDX_W] > out_idx[(k-1)*IDX_W +: IDX_W]));
  end

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (!out_valid && !out_err);
    end
  end

endmodule

bind fivehot_index_enc fhe_checker #(
  .IN_W(IN_W), .HOT(HOT), .OW(HOT*$clog2(IN_W))
) u_fhe_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_vec   (in_vec),
  .out_valid(out_valid),
  .out_idx  (out_idx),
  .out_err  (out_err)
);

// File: tb/fivehot_index_enc_bench.sv
module fivehot_index_enc_bench;

  localparam int IN_W = 16;
  localparam int HOT  = 5;
  localparam int OW   = 20;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [IN_W-1:0] in_vec;
  logic            out_valid;
  logic [OW-1:0]   out_idx;
  logic            out_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  fivehot_index_enc #(.IN_W(IN_W), .HOT(HOT)) u_fivehot_index_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_idx(out_idx), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Pipeline history of driven inputs
  logic            h0_v, h1_v;
  logic [IN_W-1:0] h0_vec, h1_vec;
  string           h0_tag, h1_tag;
  logic [OW-1:0]   last_word;
  logic            have_last;

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: scan from the top bit down, filling the top slot first
  task automatic ref_model(input logic [IN_W-1:0] v,
                           output logic [OW-1:0] w, output logic e);
    int slot;
    w = '0;
    e = ($countones(v) != HOT);
    if (!e) begin
      slot = HOT - 1;
      for (int b = IN_W - 1; b >= 0; b--) begin
        if (v[b]) begin
          w[slot*4 +: 4] = 4'(b);
          slot--;
        end
      end
    end
  endtask

  task automatic step(input logic v, input logic [IN_W-1:0] vec, input string tag);
    logic [OW-1:0] ew;
    logic          ee;
    @(negedge clk);
    check(out_valid === h1_v, "R2 valid latency", 32'(out_valid), 32'(h1_v));
    if (h1_v) begin
      ref_model(h1_vec, ew, ee);
      check(out_err === ee, {h1_tag, " R6 err flag"}, 32'(out_err), 32'(ee));
      check(out_idx === ew, {h1_tag, " word"}, 32'(out_idx), 32'(ew));
      last_word = ew;
      have_last = 1'b1;
    end else begin
      check(out_err === 1'b0, "R10 err while idle", 32'(out_err), 32'd0);
      if (have_last)
        check(out_idx === last_word, "R9 hold while idle", 32'(out_idx), 32'(last_word));
    end
    h1_v = h0_v; h1_vec = h0_vec; h1_tag = h0_tag;
    h0_v = v;    h0_vec = vec;    h0_tag = tag;
    in_valid = v;
    in_vec   = vec;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, '0, "idle");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_vec = '0;
    h0_v = 1'b0; h1_v = 1'b0; h0_vec = '0; h1_vec = '0;
    h0_tag = ""; h1_tag = ""; have_last = 1'b0; last_word = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;  // ignored while reset is held
    in_vec   = 16'h001F;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid in reset", 32'(out_valid), 32'd0);
    check(out_err === 1'b0, "R1 err in reset", 32'(out_err), 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid after reset", 32'(out_valid), 32'd0);
    check(out_err === 1'b0, "R1 err after reset", 32'(out_err), 32'd0);
  endtask

  task automatic t_example();
    step(1'b1, 16'hC007, "R4");
    flush();
    check(last_word === 20'hFE210, "R4 example word", 32'(last_word), 32'hFE210);
  endtask

  task automatic t_boundaries();
    step(1'b1, 16'h001F, "R5 all low");
    flush();
    check(last_word === 20'h43210, "R5 all low word", 32'(last_word), 32'h43210);
    step(1'b1, 16'hF800, "R5 all high");
    flush();
    check(last_word === 20'hFEDCB, "R5 all high word", 32'(last_word), 32'hFEDCB);
    step(1'b1, 16'h0F01, "R5 one low");
    step(1'b1, 16'h800F, "R5 four low");
    flush();
  endtask

  task automatic t_exhaustive();
    for (int v = 0; v < (1 << IN_W); v++) begin
      if ($countones(v[IN_W-1:0]) == HOT) step(1'b1, v[IN_W-1:0], "R3 R8 R5");
    end
    flush();
  endtask

  task automatic t_errors();
    logic [IN_W-1:0] r;
    step(1'b1, 16'h0000, "R6 zero");
    step(1'b1, 16'hFFFF, "R6 all ones");
    step(1'b1, 16'h0F00, "R6 four hot");
    step(1'b1, 16'h3F00, "R6 six hot");
    flush();
    for (int i = 0; i < 200; i++) begin
      r = IN_W'($urandom);
      if ($countones(r) == HOT) r[0] = ~r[0];
      step(1'b1, r, "R6 random");
      if (i % 7 == 0) step(1'b0, '0, "idle");
    end
    flush();
  endtask

  task automatic t_low_over();
    step(1'b1, 16'h003F, "R7 six low");
    step(1'b1, 16'h007F, "R7 seven low");
    step(1'b1, 16'h00FF, "R7 eight low");
    step(1'b1, 16'h01FE, "R7 seven low plus high");
    flush();
  endtask

  task automatic t_hold();
    step(1'b1, 16'h8421, "R9 setup");
    for (int i = 0; i < 6; i++) step(1'b0, 16'hFFFF, "idle");
  endtask

  initial begin
    t_reset();
    t_example();
    t_boundaries();
    t_hold();
    t_errors();
    t_low_over();
    t_exhaustive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule